// File: doc/BRIEF.md
# Multi-line DMA Transmit Scanner

This block is the output side of a sixteen-line serial multiplexer. Every line owns a current memory address and a byte count. A per-line busy-sending bit tells the scanner which lines still have data to send. The scanner walks these lines in round-robin order. For each line it serves, it reads one byte through a single-outstanding memory read port and hands that byte to the line's serialiser. It then moves the address forward and the count toward zero. When a count runs out, the scanner drops the line's sending bit and raises a transmit-complete flag. Software notices which lines finished by comparing the sending register with its own copy.

The host sees four registers through a two-bit select: control/status, current address, byte count and line-active. The low bits of control/status pick the line whose address and count registers the host reads and writes. Control/status also holds three interrupt-enable bits, the transmit-complete flag and a memory-error flag. A byte count is loaded as the negative of the number of characters to send. The scanner counts it up, and the line stops when the count reaches zero.

Top module: `txmux_scan`

## Requirements
- R1: After reset, control/status reads 0, the active register reads 0, `irq` is 0, `mem_req` is 0 and `tx_load` is 0.
- R2: Control/status bits [3:0] select a line. Host select 1 reads and writes that line's current address, and select 2 reads and writes its byte count. Each line keeps its own values.
- R3: The active register is host select 3, with bit n for line n. Writing a 1 sets a bit and writing a 0 has no effect. The hardware clears a line's bit when that line stops.
- R4: Each service of a line is one memory read at the line's current address. The returned byte is presented on `tx_data` while exactly one `tx_load` bit, the line's, is high. The address and the count then both increase by one.
- R5: A line whose count reaches zero after a byte loses its active bit, and control/status bit 15 is set. Writing bit 15 as 0 clears the flag. Writing it as 1 leaves the flag unchanged.
- R6: The scanner picks the next line after the last one it served, wrapping around. It only picks lines that are active and whose `tx_busy` is low. A busy line is never served.
- R7: A read that returns `mem_err` does the following: it sets control/status bit 10, clears the line's active bit, loads no byte, and leaves the line's address and count unchanged. Writing 1 to bit 8 clears bit 10.
- R8: Writing a count of -1 (16'hFFFF) to an active line makes it send at most one more character before it stops.
- R9: A line activated with a count of 0 stops without any memory read, and bit 15 is set.
- R10: Enable bits 6, 12 and 13 read back where they were written. `irq` = bit6 & ((bit13 & bit15) | (bit12 & bit10)).
- R11: Once `mem_req` rises it stays high with a stable `mem_addr` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 ctrl, 1 address, 2 count, 3 active |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected register contents |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Read complete, data and error valid |
| mem_data | input | 8 | Read byte |
| mem_err | input | 1 | Nonexistent memory on this read |
| tx_busy | input | 16 | Per-line serialiser busy |
| tx_load | output | 16 | One-hot byte hand-over strobe |
| tx_data | output | 8 | Byte handed over |
| irq | output | 1 | Gated interrupt request |

## Verification
The hardest condition to reach from the ports is a count rewrite to -1 that lands while that line's byte read is in flight. A second hard condition is a line whose serialiser stays busy while it is active. To set up the first, the bench stretches the serialiser busy time so that fetches are far apart. It waits for the first byte of a long transfer and then writes -1. To set up the second, it holds one `tx_busy` bit high, checks that no byte is loaded, and then releases it. Random rounds activate several lines together with random busy lengths, so the round-robin order and the busy skipping get exercised.

// File: rtl/txmux_pkg.sv
// Shared definitions for the multi-line transmit scanner.
package txmux_pkg;
    typedef enum logic [0:0] {S_IDLE, S_FETCH} scan_state_t;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_ACT  = 2'd3;

    localparam int B_IE_MASTER = 6;
    localparam int B_NXM_CLR   = 8;
    localparam int B_NXM       = 10;
    localparam int B_IE_ERR    = 12;
    localparam int B_IE_TX     = 13;
    localparam int B_TXDONE    = 15;
endpackage

// File: rtl/txmux_line_regs.sv
// Per-line current address and byte count storage.
// Assumes: a host write to a line wins over a hardware advance of the same line in the same cycle.
// Two read ports: one for the host-selected line, one for the line being serviced.
module txmux_line_regs #(
    parameter int N  = 16,
    parameter int DW = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] host_line,
    input  logic          host_addr_we,
    input  logic          host_cnt_we,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_addr,
    output logic [DW-1:0] host_cnt,
    input  logic          adv,
    input  logic [IW-1:0] adv_line,
    input  logic [IW-1:0] svc_line,
    output logic [DW-1:0] svc_addr,
    output logic [DW-1:0] svc_cnt
);
    logic [DW-1:0] addr_q [N];
    logic [DW-1:0] cnt_q  [N];

    for (genvar g = 0; g < N; g++) begin : g_line
        // Address register of one line: host load, else advance by one.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  addr_q[g] <= '0;
            else if (host_addr_we && host_line == IW'(g)) addr_q[g] <= host_wdata;
            else if (adv && adv_line == IW'(g))           addr_q[g] <= addr_q[g] + 1'b1;
        end
        // Count register of one line: host load, else step toward zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  cnt_q[g] <= '0;
            else if (host_cnt_we && host_line == IW'(g))  cnt_q[g] <= host_wdata;
            else if (adv && adv_line == IW'(g))           cnt_q[g] <= cnt_q[g] + 1'b1;
        end
    end

    // Read ports.
    always_comb begin
        host_addr = addr_q[host_line];
        host_cnt  = cnt_q[host_line];
        svc_addr  = addr_q[svc_line];
        svc_cnt   = cnt_q[svc_line];
    end
endmodule

// File: rtl/txmux_rr_pick.sv
// Round-robin picker: the first requesting line after `last`, wrapping around.
// The line `last` itself has the lowest priority.
module txmux_rr_pick #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          vld,
    output logic [IW-1:0] line
);
    // Scan from furthest to nearest so that the nearest request wins.
    always_comb begin
        vld  = 1'b0;
        line = last;
        for (int i = N; i >= 1; i--) begin
            logic [IW-1:0] idx;
            idx = IW'((int'(last) + i) % N);
            if (req[idx]) begin
                vld  = 1'b1;
                line = idx;
            end
        end
    end
endmodule

// File: rtl/txmux_fetch_fsm.sv
// Fetch sequencer. In IDLE it takes the picked line. A zero count is retired at once;
// any other count starts one memory read. On the acknowledge, the byte goes out (or the
// error is flagged) and the line is retired when its count reaches zero.
// Assumes: one outstanding read, and the acknowledge carries both data and error.
module txmux_fetch_fsm #(
    parameter int N  = 16,
    parameter int DW = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pick_vld,
    input  logic [IW-1:0] pick_line,
    input  logic [DW-1:0] svc_cnt,
    output logic [IW-1:0] svc_idx,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [7:0]    mem_data,
    output logic          mem_req,
    output logic [N-1:0]  tx_load,
    output logic [7:0]    tx_data,
    output logic          adv,
    output logic [IW-1:0] adv_line,
    output logic          retire,
    output logic [IW-1:0] retire_line,
    output logic          done_p,
    output logic          err_p
);
    import txmux_pkg::*;

    scan_state_t   state_q;
    logic [IW-1:0] line_q;
    logic [IW-1:0] last_q;
    logic          zero_cnt;
    logic          last_byte;
    logic          good_ack;

    assign zero_cnt  = (svc_cnt == '0);
    assign last_byte = (svc_cnt == '1);
    assign good_ack  = (state_q == S_FETCH) && mem_ack && !mem_err;

    // Sequencer state, serviced line and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            line_q  <= '0;
            last_q  <= IW'(N - 1);
        end else begin
            case (state_q)
                S_IDLE: if (pick_vld) begin
                    last_q <= pick_line;
                    line_q <= pick_line;
                    if (!zero_cnt) state_q <= S_FETCH;
                end
                S_FETCH: if (mem_ack) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state and the acknowledge.
    always_comb begin
        svc_idx     = (state_q == S_IDLE) ? pick_line : line_q;
        mem_req     = (state_q == S_FETCH);
        tx_load     = good_ack ? (N'(1) << line_q) : '0;
        tx_data     = mem_data;
        adv         = good_ack;
        adv_line    = line_q;
        retire_line = svc_idx;
        done_p      = 1'b0;
        err_p       = 1'b0;
        retire      = 1'b0;
        if (state_q == S_IDLE && pick_vld && zero_cnt) begin
            retire = 1'b1;
            done_p = 1'b1;
        end else if (state_q == S_FETCH && mem_ack) begin
            if (mem_err) begin
                retire = 1'b1;
                err_p  = 1'b1;
            end else if (last_byte) begin
                retire = 1'b1;
                done_p = 1'b1;
            end
        end
    end

    // The scheduling pointer is kept internal; only the picker uses it.
    logic [IW-1:0] unused_last;
    assign unused_last = last_q;
endmodule

// File: rtl/txmux_scan.sv
// Multi-line DMA transmit scanner top.
// Holds the control/status register and the line-active register. Ties together the
// line registers, the round-robin picker and the fetch sequencer.
// Assumes N <= DW and N <= 16, so the line select fits in control bits [3:0].
module txmux_scan #(
    parameter int N  = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [1:0]    host_sel,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [7:0]    mem_data,
    input  logic          mem_err,
    input  logic [N-1:0]  tx_busy,
    output logic [N-1:0]  tx_load,
    output logic [7:0]    tx_data,
    output logic          irq
);
    import txmux_pkg::*;
    localparam int IW = $clog2(N);

    logic [IW-1:0] sel_q;
    logic          ie_master_q, ie_err_q, ie_tx_q;
    logic          txflag_q, nxm_q;
    logic [N-1:0]  active_q;

    logic          wr_ctrl, wr_act;
    logic [DW-1:0] host_addr, host_cnt, svc_addr, svc_cnt;
    logic [IW-1:0] svc_idx, adv_line, retire_line, pick_line, last_line;
    logic          pick_vld, adv, retire, done_p, err_p;
    logic [N-1:0]  clr_mask, set_mask;

    assign wr_ctrl  = host_wr && host_sel == SEL_CTRL;
    assign wr_act   = host_wr && host_sel == SEL_ACT;
    assign clr_mask = retire ? (N'(1) << retire_line) : '0;
    assign set_mask = wr_act ? host_wdata[N-1:0] : '0;

    // Control/status register: line select, enables, completion and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q       <= '0;
            ie_master_q <= 1'b0;
            ie_err_q    <= 1'b0;
            ie_tx_q     <= 1'b0;
            txflag_q    <= 1'b0;
            nxm_q       <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                sel_q       <= host_wdata[IW-1:0];
                ie_master_q <= host_wdata[B_IE_MASTER];
                ie_err_q    <= host_wdata[B_IE_ERR];
                ie_tx_q     <= host_wdata[B_IE_TX];
            end
            if (done_p)       txflag_q <= 1'b1;
            else if (wr_ctrl) txflag_q <= txflag_q & host_wdata[B_TXDONE];
            if (err_p)                               nxm_q <= 1'b1;
            else if (wr_ctrl && host_wdata[B_NXM_CLR]) nxm_q <= 1'b0;
        end
    end

    // Line-active register: host sets, hardware clears, a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= '0;
        else        active_q <= (active_q & ~clr_mask) | set_mask;
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata = '0;
        case (host_sel)
            SEL_CTRL: begin
                host_rdata[IW-1:0]        = sel_q;
                host_rdata[B_IE_MASTER]   = ie_master_q;
                host_rdata[B_NXM]         = nxm_q;
                host_rdata[B_IE_ERR]      = ie_err_q;
                host_rdata[B_IE_TX]       = ie_tx_q;
                host_rdata[B_TXDONE]      = txflag_q;
            end
            SEL_ADDR: host_rdata = host_addr;
            SEL_CNT:  host_rdata = host_cnt;
            default:  host_rdata[N-1:0] = active_q;
        endcase
    end

    // Interrupt request.
    assign irq = ie_master_q & ((ie_tx_q & txflag_q) | (ie_err_q & nxm_q));
    assign mem_addr = svc_addr;

    txmux_line_regs #(.N(N), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_line(sel_q),
        .host_addr_we(host_wr && host_sel == SEL_ADDR),
        .host_cnt_we(host_wr && host_sel == SEL_CNT),
        .host_wdata(host_wdata),
        .host_addr(host_addr), .host_cnt(host_cnt),
        .adv(adv), .adv_line(adv_line),
        .svc_line(svc_idx), .svc_addr(svc_addr), .svc_cnt(svc_cnt)
    );

    txmux_rr_pick #(.N(N)) u_pick (
        .req(active_q & ~tx_busy), .last(last_line),
        .vld(pick_vld), .line(pick_line)
    );

    txmux_fetch_fsm #(.N(N), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pick_vld(pick_vld), .pick_line(pick_line),
        .svc_cnt(svc_cnt), .svc_idx(svc_idx),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_data(mem_data),
        .mem_req(mem_req), .tx_load(tx_load), .tx_data(tx_data),
        .adv(adv), .adv_line(adv_line),
        .retire(retire), .retire_line(retire_line),
        .done_p(done_p), .err_p(err_p)
    );

    // The picker's pointer is the sequencer's last served line.
    assign last_line = u_fsm.last_q;
endmodule

// File: rtl/txmux_scan_chk.sv
// Property checker for the transmit scanner, bound to the top.
module txmux_scan_chk #(
    parameter int N  = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic [DW-1:0] mem_addr,
    input logic [N-1:0]  tx_load,
    input logic          done_p,
    input logic          txflag,
    input logic          nxm,
    input logic          irq
);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
    p_load_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_load));
    p_load_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_load) |-> (mem_req && mem_ack && !mem_err));
    p_err_sets_nxm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> nxm);
    p_done_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> txflag);
    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (txflag || nxm));
endmodule

bind txmux_scan txmux_scan_chk #(.N(N), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err), .mem_addr(mem_addr),
    .tx_load(tx_load), .done_p(done_p), .txflag(txflag_q), .nxm(nxm_q), .irq(irq)
);

// File: tb/txmux_scan_tb_top.sv
module txmux_scan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam logic [15:0] IE   = 16'h3040;
    localparam logic [15:0] KEEP = 16'h8000;

    logic        clk = 0, rst_n = 0;
    logic        host_wr = 0;
    logic [1:0]  host_sel = 0;
    logic [15:0] host_wdata = 0, host_rdata;
    logic        mem_req, mem_ack, mem_err;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data, tx_data;
    logic [N-1:0] tx_busy, tx_load, hold_busy;
    logic        irq;

    int checks = 0, errors = 0;
    int exp_left [N];
    logic [15:0] exp_addr [N];
    int nload [N];
    int busy_cnt [N];
    int busy_mode = 0;
    int order_log [64];
    int order_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txmux_scan dut_i (.*);

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic is_bad(input logic [15:0] a);
        return a[15:12] == 4'hF;
    endfunction

    assign mem_data = exp_byte(mem_addr);
    assign mem_err  = is_bad(mem_addr);

    // Memory model: acknowledge one cycle after the request is seen.
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 0;
        else        mem_ack <= mem_req & ~mem_ack;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Serialiser model: check each handed byte, then stay busy for a while.
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (busy_cnt[i] > 0) busy_cnt[i]--;
            if (rst_n && tx_load[i]) begin
                chk(tx_data == exp_byte(exp_addr[i]), "R4 byte", tx_data, exp_byte(exp_addr[i]));
                chk(exp_left[i] > 0, "R4 unexpected load", i, -1);
                chk(!tx_busy[i], "R6 load to busy line", i, -1);
                exp_left[i]--;
                exp_addr[i]++;
                nload[i]++;
                if (order_n < 64) begin order_log[order_n] = i; order_n++; end
                busy_cnt[i] = (busy_mode == 1) ? int'($urandom_range(0, 3)) :
                              (busy_mode == 2) ? 8 : 0;
            end
            tx_busy[i] = hold_busy[i] || busy_cnt[i] > 0;
        end
    end

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1; host_sel = s; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask
    task automatic rd(input logic [1:0] s, output logic [15:0] d);
        @(negedge clk);
        host_sel = s;
        #1 d = host_rdata;
    endtask
    task automatic setup_line(input int l, input logic [15:0] a, input int n);
        wr(0, KEEP | IE | 16'(l));
        wr(1, a);
        wr(2, 16'h0 - 16'(n));
        exp_addr[l] = a; exp_left[l] = n; nload[l] = 0;
    endtask
    task automatic wait_idle();
        logic [15:0] v;
        for (int k = 0; k < 3000; k++) begin
            rd(3, v);
            if (v == 0) break;
        end
        chk(v == 0, "R3 active cleared by hardware", v, 0);
    endtask
    task automatic check_line(input int l, input logic [15:0] a, input logic [15:0] c, input string tag);
        logic [15:0] v;
        wr(0, KEEP | IE | 16'(l));
        rd(1, v); chk(v == a, {tag, " address"}, v, a);
        rd(2, v); chk(v == c, {tag, " count"}, v, c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, a0, a1;
        int n0;
        process::self().srandom(32'd1277);
        hold_busy = '0;
        for (int i = 0; i < N; i++) begin
            exp_left[i] = 0; exp_addr[i] = 0; nload[i] = 0; busy_cnt[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        rd(0, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(3, v); chk(v == 0, "R1 active", v, 0);
        chk(irq == 0 && mem_req == 0 && tx_load == 0, "R1 outputs", {irq, mem_req}, 0);

        // R2: per-line register select
        wr(0, 16'h0001); wr(1, 16'h1234); wr(2, 16'hFFF0);
        wr(0, 16'h0002); wr(1, 16'h0ABC);
        check_line(1, 16'h1234, 16'hFFF0, "R2 line1");
        check_line(2, 16'h0ABC, 16'h0000, "R2 line2");

        // R10: enables read back
        wr(0, IE);
        rd(0, v); chk((v & IE) == IE, "R10 enables", v & IE, IE);
        chk(irq == 0, "R10 irq idle", irq, 0);

        // R6: round robin between lines 2 and 5
        setup_line(2, 16'h0100, 3);
        setup_line(5, 16'h0500, 3);
        order_n = 0;
        wr(3, 16'h0024);
        wait_idle();
        for (int k = 0; k < 6; k++)
            chk(order_log[k] == ((k % 2 == 0) ? 2 : 5), "R6 order", order_log[k], (k % 2 == 0) ? 2 : 5);
        check_line(2, 16'h0103, 16'h0000, "R4 line2");
        check_line(5, 16'h0503, 16'h0000, "R4 line5");
        rd(0, v); chk(v[15] == 1, "R5 flag set", v[15], 1);
        chk(irq == 1, "R10 irq on completion", irq, 1);

        // R5: flag write-1 keeps, write-0 clears
        wr(0, KEEP | IE); rd(0, v); chk(v[15] == 1, "R5 write 1 keeps", v[15], 1);
        wr(0, IE);        rd(0, v); chk(v[15] == 0, "R5 write 0 clears", v[15], 0);
        chk(irq == 0, "R10 irq cleared", irq, 0);

        // R6/R3: busy line skipped, writing 0 to active has no effect
        hold_busy[4] = 1;
        setup_line(4, 16'h0400, 2);
        wr(3, 16'h0010);
        repeat (30) @(negedge clk);
        chk(nload[4] == 0, "R6 busy line skipped", nload[4], 0);
        wr(3, 16'h0000);
        rd(3, v); chk(v == 16'h0010, "R3 write 0 ignored", v, 16'h0010);
        hold_busy[4] = 0;
        wait_idle();
        chk(nload[4] == 2, "R4 line4 bytes", nload[4], 2);
        wr(0, IE);

        // R7: memory error
        setup_line(7, 16'hF010, 3);
        wr(3, 16'h0080);
        wait_idle();
        rd(0, v); chk(v[10] == 1, "R7 error flag", v[10], 1);
        chk(nload[7] == 0, "R7 no load", nload[7], 0);
        chk(irq == 1, "R10 irq on error", irq, 1);
        check_line(7, 16'hF010, 16'hFFFD, "R7 no advance");
        wr(0, IE | 16'h0100);
        rd(0, v); chk(v[10] == 0, "R7 clear by bit8", v[10], 0);

        // R9: zero count retired without fetch
        setup_line(9, 16'h0900, 0);
        wr(3, 16'h0200);
        wait_idle();
        rd(0, v); chk(v[15] == 1, "R9 flag", v[15], 1);
        chk(nload[9] == 0, "R9 no load", nload[9], 0);
        check_line(9, 16'h0900, 16'h0000, "R9 untouched");
        wr(0, IE);

        // R8: stop with -1 after the first byte
        busy_mode = 2;
        setup_line(3, 16'h0200, 20);
        wr(3, 16'h0008);
        for (int k = 0; k < 500 && nload[3] == 0; k++) @(negedge clk);
        n0 = nload[3];
        wr(2, 16'hFFFF);
        wait_idle();
        chk(nload[3] <= n0 + 1, "R8 at most one more", nload[3], n0 + 1);
        rd(2, v); chk(v == 0, "R8 count zero", v, 0);
        wr(0, IE);

        // Random rounds
        busy_mode = 1;
        for (int r = 0; r < 20; r++) begin
            logic [15:0] mask, st [N];
            int nn [N];
            mask = 0;
            for (int j = 0; j < 4; j++) begin
                int l;
                l = int'($urandom_range(0, N - 1));
                if (!mask[l]) begin
                    mask[l] = 1;
                    st[l] = {4'($urandom_range(0, 14)), 12'($urandom)};
                    nn[l] = int'($urandom_range(1, 8));
                    setup_line(l, st[l], nn[l]);
                end
            end
            wr(3, mask);
            wait_idle();
            for (int l = 0; l < N; l++) if (mask[l]) begin
                chk(nload[l] == nn[l], "R4 random byte count", nload[l], nn[l]);
                check_line(l, st[l] + 16'(nn[l]), 16'h0000, "R4 random");
            end
            rd(0, v); chk(v[15] == 1, "R5 random flag", v[15], 1);
            wr(0, IE);
        end

        a0 = 0; a1 = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule